// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits on the output side of a 14-bit converter. It takes the converter's sample stream and sends one data word per sample toward the output drivers. In normal operation it adds a signed trim to each sample, limits the result to the code range, converts it to the chosen number format and can complement it.

For bring-up and link checks a 3-bit mode field replaces the real samples with a test pattern. The choices are three fixed codes, two alternating words and two pseudo-random sequences. Each pseudo-random generator can be restarted on its own.

Both sides of the path use valid/ready. A sample is accepted in a cycle where `in_valid` and `in_ready` are both high. A word leaves in a cycle where `out_valid` and `out_ready` are both high. While a word is held because `out_ready` is low, the whole two-stage path stalls, `in_ready` is low, and `out_data` stays frozen. Config fields are read in the cycle a sample is accepted and then travel with that sample. Data words are in offset binary until the format stage.

Top module: `tpg_out_path`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A sample accepted in cycle c, with `out_ready` high, appears on `out_data` with `out_valid` high in cycle c+2. In mode 000 the word is the sample plus the sign-extended 8-bit trim `cfg_offset`, which ranges from -128 to +127.
- R3: In mode 000 the sum is clamped to 0x0000 when it is negative and to 0x3FFF when it is above 0x3FFF.
- R4: Modes 001, 010 and 011 output 0x2000, 0x3FFF and 0x0000 respectively. The trim is not applied to test data in any nonzero mode.
- R5: Mode 100 outputs 0x2AAA or 0x1555, and mode 111 outputs 0x3FFF or 0x0000. One phase bit picks the word: phase 0 gives the first value of each pair. The phase is 0 after reset and flips on every accepted sample in every mode.
- R6: Mode 101 outputs bits [22:9] of a 23-bit register L. L is all ones after reset. On every accepted sample, in every mode, L shifts left and takes in L[22] xor L[17] at bit 0.
- R7: Mode 110 outputs {S[8:0], S[8:4]} of a 9-bit register S. S is all ones after reset. On every accepted sample, in every mode, S shifts left and takes in S[8] xor S[4] at bit 0.
- R8: In any cycle where `cfg_rst_long` (or `cfg_rst_short`) is high, the matching register acts as all ones in that cycle. A sample accepted in that cycle therefore gets the seed word, and the register then steps on from the seed.
- R9: `cfg_format` 00 and 11 give offset binary. 01 gives two's complement, which is the word with bit 13 flipped. 10 gives Gray code, which is w xor (w >> 1).
- R10: When `cfg_invert` is 1, the formatted word is complemented in all 14 bits.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and in the next cycle `out_valid` is still high with `out_data` unchanged.
- R12: No pattern state moves and no word is produced without an accepted sample. Every accepted sample yields exactly one output word, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 14 | Converter sample, offset binary |
| cfg_mode | input | 3 | Source select (000 normal, 001..111 patterns) |
| cfg_rst_long | input | 1 | Hold the 23-bit generator at its seed |
| cfg_rst_short | input | 1 | Hold the 9-bit generator at its seed |
| cfg_offset | input | 8 | Signed trim added in normal mode |
| cfg_invert | input | 1 | Complement the output word |
| cfg_format | input | 2 | Output number format |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | 14 | Output word |

## Verification
The value properties assume the config fields and the sample are never X and change only between clock edges. They also assume the settings present when a sample is accepted are the ones that should apply to that sample. The stall property assumes `out_ready` is driven from the same clock domain. The stimulus meets these assumptions by driving every input shortly after the rising edge from tasks, holding each sample and its settings until it is accepted, and limiting random back-pressure to one phase of the run.

// File: rtl/tpg_pkg.sv
`timescale 1ns/100ps
package tpg_pkg;
  typedef enum logic [2:0] {
    SRC_LIVE    = 3'b000,
    SRC_MID     = 3'b001,
    SRC_TOP     = 3'b010,
    SRC_BOTTOM  = 3'b011,
    SRC_CHECKER = 3'b100,
    SRC_PN_LONG = 3'b101,
    SRC_PN_SHRT = 3'b110,
    SRC_TOGGLE  = 3'b111
  } src_sel_e;

  typedef enum logic [1:0] {
    NUM_OBIN  = 2'b00,
    NUM_TWOS  = 2'b01,
    NUM_GRAY  = 2'b10,
    NUM_OBIN2 = 2'b11
  } num_fmt_e;
endpackage

// File: rtl/tpg_lfsr.sv
`timescale 1ns/100ps
module tpg_lfsr #(
  parameter int LEN = 23,
  parameter int TAP = 18,
  parameter int DW  = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  output logic [DW-1:0] word
);
  localparam logic [LEN-1:0] SEED = '1;

  logic [LEN-1:0] state;
  logic [LEN-1:0] cur;
  logic [LEN-1:0] nxt;

  always_comb begin
    cur = restart ? SEED : state;
    nxt = step ? {cur[LEN-2:0], cur[LEN-1] ^ cur[TAP-1]} : cur;
    // Left-justify the register; when narrower than the word, wrap its top bits again
    for (int i = 0; i < DW; i++) begin
      word[DW-1-i] = cur[LEN-1-(i % LEN)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= nxt;
  end
endmodule

// File: rtl/tpg_src.sv
`timescale 1ns/100ps
module tpg_src
  import tpg_pkg::*;
#(
  parameter int DW  = 14,
  parameter int OFW = 8
) (
  input  logic [2:0]     mode,
  input  logic [DW-1:0]  sample,
  input  logic [OFW-1:0] offset,
  input  logic           phase,
  input  logic [DW-1:0]  long_w,
  input  logic [DW-1:0]  short_w,
  output logic [DW-1:0]  word
);
  localparam int SW = DW + 2;

  function automatic logic [DW-1:0] alt_bits(input logic odd);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = ((i % 2) == 1) ? odd : ~odd;
    return r;
  endfunction

  localparam logic [DW-1:0] W_MID  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] W_ONES = '1;
  localparam logic [DW-1:0] W_ZERO = '0;
  localparam logic [DW-1:0] W_CHKA = alt_bits(1'b1);
  localparam logic [DW-1:0] W_CHKB = alt_bits(1'b0);
  localparam logic signed [SW-1:0] LIMIT = $signed({2'b00, W_ONES});

  logic signed [SW-1:0] sum;
  logic [DW-1:0]        trimmed;
  src_sel_e             sel;

  always_comb begin
    sum = $signed({2'b00, sample}) + $signed({{(SW-OFW){offset[OFW-1]}}, offset});
    if (sum < 0)          trimmed = W_ZERO;
    else if (sum > LIMIT) trimmed = W_ONES;
    else                  trimmed = sum[DW-1:0];
  end

  always_comb begin
    sel = src_sel_e'(mode);
    unique case (sel)
      SRC_LIVE:    word = trimmed;
      SRC_MID:     word = W_MID;
      SRC_TOP:     word = W_ONES;
      SRC_BOTTOM:  word = W_ZERO;
      SRC_CHECKER: word = phase ? W_CHKB : W_CHKA;
      SRC_PN_LONG: word = long_w;
      SRC_PN_SHRT: word = short_w;
      SRC_TOGGLE:  word = phase ? W_ZERO : W_ONES;
      default:     word = trimmed;
    endcase
  end
endmodule

// File: rtl/tpg_fmt.sv
`timescale 1ns/100ps
module tpg_fmt
  import tpg_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic [1:0]    fmt,
  input  logic          invert,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] result
);
  localparam logic [DW-1:0] SIGN = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] coded;

  always_comb begin
    unique case (num_fmt_e'(fmt))
      NUM_TWOS: coded = word ^ SIGN;
      NUM_GRAY: coded = word ^ (word >> 1);
      default:  coded = word;
    endcase
    result = invert ? ~coded : coded;
  end
endmodule

// File: rtl/tpg_out_path.sv
`timescale 1ns/100ps
module tpg_out_path #(
  parameter int DW        = 14,
  parameter int OFW       = 8,
  parameter int LONG_LEN  = 23,
  parameter int LONG_TAP  = 18,
  parameter int SHORT_LEN = 9,
  parameter int SHORT_TAP = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  input  logic [2:0]     cfg_mode,
  input  logic           cfg_rst_long,
  input  logic           cfg_rst_short,
  input  logic [OFW-1:0] cfg_offset,
  input  logic           cfg_invert,
  input  logic [1:0]     cfg_format,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data
);
  logic          adv;
  logic          fire;
  logic          phase;
  logic [DW-1:0] long_w;
  logic [DW-1:0] short_w;
  logic [DW-1:0] src_w;
  logic [DW-1:0] fmt_w;

  logic          s1_valid;
  logic [DW-1:0] s1_word;
  logic [1:0]    s1_fmt;
  logic          s1_inv;

  // Single stall point: both stages move only when the output slot can drain
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign fire     = in_valid && adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= 1'b0;
    else if (fire) phase <= ~phase;
  end

  tpg_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP), .DW(DW)) u_pn_long (
    .clk(clk), .rst_n(rst_n), .restart(cfg_rst_long), .step(fire), .word(long_w)
  );

  tpg_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .DW(DW)) u_pn_short (
    .clk(clk), .rst_n(rst_n), .restart(cfg_rst_short), .step(fire), .word(short_w)
  );

  tpg_src #(.DW(DW), .OFW(OFW)) u_src (
    .mode(cfg_mode), .sample(in_data), .offset(cfg_offset), .phase(phase),
    .long_w(long_w), .short_w(short_w), .word(src_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_word  <= '0;
      s1_fmt   <= '0;
      s1_inv   <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_word  <= src_w;
      s1_fmt   <= cfg_format;
      s1_inv   <= cfg_invert;
    end
  end

  tpg_fmt #(.DW(DW)) u_fmt (
    .fmt(s1_fmt), .invert(s1_inv), .word(s1_word), .result(fmt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_data  <= fmt_w;
    end
  end
endmodule

// File: rtl/tpg_out_path_chk.sv
`timescale 1ns/100ps
module tpg_out_path_chk #(
  parameter int DW  = 14,
  parameter int OFW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [DW-1:0]  in_data,
  input logic [2:0]     cfg_mode,
  input logic [OFW-1:0] cfg_offset,
  input logic           cfg_invert,
  input logic [1:0]     cfg_format,
  input logic           out_valid,
  input logic           out_ready,
  input logic [DW-1:0]  out_data
);
  localparam logic [DW-1:0] MIDW = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [DW-1:0] ZERO = '0;

  logic acc;
  logic plain;
  assign acc   = in_valid && in_ready;
  assign plain = (cfg_format == 2'b00) && !cfg_invert;

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r11_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc, 2) && $past(in_ready, 1)) |-> out_valid);

  a_r4_mid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cfg_mode == 3'b001 && plain, 2) && $past(in_ready, 1))
      |-> (out_data == MIDW));

  a_r3_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cfg_mode == 3'b000 && plain && in_data == ONES && !cfg_offset[OFW-1], 2)
      && $past(in_ready, 1)) |-> (out_data == ONES));

  a_r3_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cfg_mode == 3'b000 && plain && in_data == ZERO && cfg_offset[OFW-1], 2)
      && $past(in_ready, 1)) |-> (out_data == ZERO));

  a_r9_twos_mid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cfg_mode == 3'b001 && cfg_format == 2'b01 && !cfg_invert, 2)
      && $past(in_ready, 1)) |-> (out_data == ZERO));

  a_r10_inv_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cfg_mode == 3'b011 && cfg_format == 2'b00 && cfg_invert, 2)
      && $past(in_ready, 1)) |-> (out_data == ONES));
endmodule

bind tpg_out_path tpg_out_path_chk #(.DW(DW), .OFW(OFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .cfg_mode(cfg_mode), .cfg_offset(cfg_offset),
  .cfg_invert(cfg_invert), .cfg_format(cfg_format), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_tpg_out_path.sv
`timescale 1ns/100ps
module sim_tpg_out_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_data = '0;
  logic [2:0]  cfg_mode = '0;
  logic        cfg_rst_long = 1'b0;
  logic        cfg_rst_short = 1'b0;
  logic [7:0]  cfg_offset = '0;
  logic        cfg_invert = 1'b0;
  logic [1:0]  cfg_format = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [13:0] out_data;

  tpg_out_path u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_mode(cfg_mode), .cfg_rst_long(cfg_rst_long),
    .cfg_rst_short(cfg_rst_short), .cfg_offset(cfg_offset),
    .cfg_invert(cfg_invert), .cfg_format(cfg_format), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    done = 0;
  bit    bp_en = 0;
  string ph_tag = "";
  int    q_data[$];
  int    q_cyc[$];
  bit    q_lat[$];
  string q_tag[$];
  int    m_long = 32'h7FFFFF;
  int    m_short = 32'h1FF;
  int    m_phase = 0;
  bit    was_stall = 0;
  int    last_out = 0;
  int    rnd = 32'h1ACE5;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_word(int d, int mode, int off, int fmt, int inv,
                                    int ph, int l, int s);
    int v;
    case (mode)
      0: begin
        v = d + off;
        if (v < 0) v = 0;
        if (v > 16383) v = 16383;
      end
      1: v = 32'h2000;
      2: v = 32'h3FFF;
      3: v = 0;
      4: v = ph ? 32'h1555 : 32'h2AAA;
      5: v = (l >> 9) & 32'h3FFF;
      6: v = ((s & 32'h1FF) << 5) | ((s >> 4) & 32'h1F);
      default: v = ph ? 0 : 32'h3FFF;
    endcase
    if (fmt == 1) v = v ^ 32'h2000;
    else if (fmt == 2) v = v ^ (v >> 1);
    if (inv != 0) v = v ^ 32'h3FFF;
    return v;
  endfunction

  function automatic string tag_of(int d, int mode, int off, int fmt, int inv);
    if (ph_tag != "") return ph_tag;
    case (mode)
      0: begin
        if (d + off < 0 || d + off > 16383) return "R3";
        if (fmt != 0) return "R9";
        if (inv != 0) return "R10";
        return "R2";
      end
      1, 2, 3: return (fmt != 0) ? "R9" : (inv != 0) ? "R10" : "R4";
      4, 7: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Monitor and reference model, evaluated mid-cycle
  always @(negedge clk) begin
    int cl;
    int cs;
    int off;
    cyc++;
    if (rst_n) begin
      if (was_stall) begin
        chk(out_valid && out_data == last_out, "R11", out_data, last_out);
      end
      if (out_valid && !out_ready) chk(!in_ready, "R11", in_ready, 0);
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) begin
          chk(0, "R12", out_data, -1);
        end else begin
          int e;
          int ec;
          bit el;
          string et;
          e = q_data.pop_front();
          ec = q_cyc.pop_front();
          el = q_lat.pop_front();
          et = q_tag.pop_front();
          chk(out_data == e, et, out_data, e);
          if (el) chk(cyc - ec == 2, "R2", cyc - ec, 2);
        end
      end
      was_stall = out_valid && !out_ready;
      last_out = out_data;

      cl = cfg_rst_long ? 32'h7FFFFF : m_long;
      cs = cfg_rst_short ? 32'h1FF : m_short;
      if (in_valid && in_ready) begin
        off = $signed(cfg_offset);
        q_data.push_back(model_word(in_data, cfg_mode, off, cfg_format, cfg_invert,
                                    m_phase, cl, cs));
        q_cyc.push_back(cyc);
        q_lat.push_back(!bp_en);
        q_tag.push_back(tag_of(in_data, cfg_mode, off, cfg_format, cfg_invert));
        cl = ((cl << 1) & 32'h7FFFFF) | (((cl >> 22) ^ (cl >> 17)) & 1);
        cs = ((cs << 1) & 32'h1FF) | (((cs >> 8) ^ (cs >> 4)) & 1);
        m_phase = 1 - m_phase;
      end
      m_long = cl;
      m_short = cs;
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    #1;
    if (bp_en) begin
      rnd = (rnd << 1) ^ (((rnd >> 19) ^ (rnd >> 2)) & 1);
      out_ready = rnd[0] | rnd[3];
    end else begin
      out_ready = 1'b1;
    end
  end

  task automatic send(input int d, input int mode, input int off, input int fmt,
                      input int inv, input bit rl, input bit rs);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_data = d[13:0];
    cfg_mode = mode[2:0];
    cfg_offset = off[7:0];
    cfg_format = fmt[1:0];
    cfg_invert = inv[0];
    cfg_rst_long = rl;
    cfg_rst_short = rs;
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      cfg_rst_long = 1'b0;
      cfg_rst_short = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);

    // R4, R9, R10: fixed codes through every format and invert setting
    for (int m = 1; m <= 3; m++)
      for (int f = 0; f < 4; f++)
        for (int v = 0; v < 2; v++)
          send(m * 91, m, -77, f, v, 0, 0);
    idle(4);

    // R2, R3, R9, R10: every input code with varied trims and formats
    for (int i = 0; i < 16384; i++) begin
      int off;
      off = (i % 3 == 0) ? 127 : (i % 3 == 1) ? -128 : ((i * 37) % 256) - 128;
      send(i, 0, off, i % 4, (i / 7) % 2, 0, 0);
    end
    send(16383, 0, 1, 0, 0, 0, 0);
    send(0, 0, -1, 0, 0, 0, 0);
    idle(4);

    // R5, R6, R7, R12: pattern modes with idle gaps and live samples in between
    foreach (ph_list[j]) begin
      for (int i = 0; i < 300; i++) begin
        send(i * 13, ph_list[j], 5, (i / 50) % 4, (i / 100) % 2, 0, 0);
        if (i % 5 == 0) idle(2);
        if (i % 50 == 49) send(i, 0, 3, 0, 0, 0, 0);
      end
    end
    idle(4);

    // R8: generator restarts
    ph_tag = "R8";
    for (int i = 0; i < 20; i++) send(i, 5, 0, 0, 0, 0, 0);
    send(0, 5, 0, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) send(i, 5, 0, 0, 0, 0, 0);
    for (int i = 0; i < 15; i++) send(i, 6, 0, 0, 0, 0, 0);
    send(0, 6, 0, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) send(i, 6, 0, 0, 0, 0, 0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    cfg_rst_long = 1'b1;
    cfg_rst_short = 1'b1;
    idle(2);
    send(0, 5, 0, 0, 0, 0, 0);
    send(0, 6, 0, 0, 0, 0, 0);
    idle(4);

    // R11: random back-pressure across mixed sources
    ph_tag = "R11";
    bp_en = 1;
    for (int i = 0; i < 2000; i++) begin
      send((i * 2731) % 16384, i % 8, (i % 256) - 128, (i / 8) % 4, (i / 32) % 2, 0, 0);
    end
    bp_en = 0;
    idle(12);

    // R12: every accepted sample has produced its word, nothing extra
    ph_tag = "";
    chk(q_data.size() == 0, "R12", q_data.size(), 0);
    chk(out_valid == 1'b0, "R12", out_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int ph_list[5] = '{4, 5, 6, 7, 4};
endmodule